// File: doc/BRIEF.md
# Paged and linear memory address unit

This unit lets a CPU with a 16-bit address space reach a physical memory of up to 4 MB. It works in two ways. The first is a page translator. Any CPU address from 0x8000 to 0xBFFF falls in a 16 KB window. That address is redirected into one of 256 pages of 16 KB, and a software-written page register picks the page. All other CPU addresses pass through zero-extended. The translation is combinational and is presented on its own output.

The second way is an indirect 22-bit linear pointer held in three byte registers. A data port reads or writes the physical byte at the pointer. An add port moves the pointer by a signed byte, so software can walk through the whole physical space without paging.

Software reaches both through a small byte-wide register bus. A data-port access turns into a single-cycle strobe on the physical memory port. All register read data, including the memory byte, returns on the cycle after the request.

Top module: `paged_addr_unit`

## Requirements
- R1: For a CPU address from 0x8000 to 0xBFFF, `xlat_addr_o` equals {page register, cpu_addr[13:0]} and `win_hit_o` is 1 in the same cycle.
- R2: For any other CPU address, `xlat_addr_o` is the CPU address zero-extended to 22 bits and `win_hit_o` is 0.
- R3: The page register sits at offset 0. It is 8 bits, readable and writable, and resets to 0x00.
- R4: The pointer bytes sit at offset 1 (bits 21:16), offset 2 (bits 15:8) and offset 3 (bits 7:0). Each is readable and writable and resets to zero. Bits 7:6 of offset 1 read as 0, and writing them has no effect.
- R5: A read at offset 4 raises `mem_rd_o` for that one cycle with `mem_addr_o` equal to the pointer. The byte that memory returns on the next cycle appears on `reg_rdata_o` in that next cycle.
- R6: A write at offset 4 raises `mem_wr_o` for that one cycle, with `mem_addr_o` equal to the pointer and `mem_wdata_o` equal to the written byte.
- R7: A write at offset 5 adds the byte, taken as two's complement, to the pointer modulo 2^22. 0x7F adds 127, 0xFF subtracts 1 and 0x80 subtracts 128, so 0 minus 1 gives 0x3FFFFF.
- R8: A read at offset 5 returns 0x00.
- R9: A pointer change by an add or a byte write is used by an offset-4 access in the very next cycle.
- R10: At most one memory strobe is high in any cycle, and there is no strobe without an offset-4 access. Offsets 6 and 7 read 0x00, and writes to them change no register.
- R11: The data for a register read issued in cycle t is on `reg_rdata_o` in cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address to translate |
| win_hit_o | output | 1 | CPU address lies in the paging window |
| xlat_addr_o | output | 22 | Translated physical address |
| reg_sel_i | input | 1 | Register bus access this cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, one cycle after the request |
| mem_addr_o | output | 22 | Physical address for data-port accesses |
| mem_rd_o | output | 1 | Single-cycle memory read strobe |
| mem_wr_o | output | 1 | Single-cycle memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after `mem_rd_o` |

## Verification
The translator is driven at both edges of the window (0x8000, 0xBFFF) and just outside them (0x7FFF, 0xC000), with two different page values. This catches a wrong window decode as well as a page register that is not wired through. The pointer is moved by +127, -128 and -1, and also across both wrap points (0 to 0x3FFFFF and back). This separates correct sign extension and modulo wrap from a plain unsigned add or an add clipped to 8 bits. Data-port reads and writes are issued right after pointer changes, and every register read is compared on the following cycle, so an off-by-one-cycle pointer or a wrong return cycle is visible.

// File: rtl/paddr_pkg.sv
package paddr_pkg;
  localparam int unsigned CPU_AW  = 16;
  localparam int unsigned PHYS_AW = 22;
  localparam int unsigned PAGE_W  = 8;
  localparam int unsigned WIN_AW  = 14;

  typedef enum logic [2:0] {
    OFF_PAGE    = 3'd0,
    OFF_LAP_HI  = 3'd1,
    OFF_LAP_MID = 3'd2,
    OFF_LAP_LO  = 3'd3,
    OFF_DATA    = 3'd4,
    OFF_ADD     = 3'd5
  } reg_off_e;
endpackage

// File: rtl/page_xlat.sv
module page_xlat #(
  parameter int unsigned CPU_AW  = 16,
  parameter int unsigned WIN_AW  = 14,
  parameter int unsigned PAGE_W  = 8,
  parameter int unsigned PHYS_AW = 22,
  parameter logic [CPU_AW-WIN_AW-1:0] WIN_TAG = 2'b10
) (
  input  logic [CPU_AW-1:0]  cpu_addr_i,
  input  logic [PAGE_W-1:0]  page_i,
  output logic               hit_o,
  output logic [PHYS_AW-1:0] phys_o
);
  assign hit_o  = (cpu_addr_i[CPU_AW-1:WIN_AW] == WIN_TAG);
  assign phys_o = hit_o ? {page_i, cpu_addr_i[WIN_AW-1:0]} : PHYS_AW'(cpu_addr_i);
endmodule

// File: rtl/lin_ptr.sv
module lin_ptr #(
  parameter int unsigned PHYS_AW = 22
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_lane_i,  // 0 hi, 1 mid, 2 lo
  input  logic               add_en_i,
  input  logic [7:0]         wdata_i,
  output logic [PHYS_AW-1:0] lap_o
);
  localparam int unsigned HI_W = PHYS_AW - 16;

  logic [PHYS_AW-1:0] lap_q;
  logic [PHYS_AW-1:0] step;

  assign step  = {{(PHYS_AW-8){wdata_i[7]}}, wdata_i};
  assign lap_o = lap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lap_q <= '0;
    end else if (add_en_i) begin
      lap_q <= lap_q + step;  // wraps modulo 2^PHYS_AW
    end else if (wr_en_i) begin
      case (wr_lane_i)
        2'd0:    lap_q[PHYS_AW-1:16] <= wdata_i[HI_W-1:0];
        2'd1:    lap_q[15:8]         <= wdata_i;
        default: lap_q[7:0]          <= wdata_i;
      endcase
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i || add_en_i) |=> $stable(lap_q)); // R4
  AST_ADD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_en_i && wdata_i == 8'h00) |=> $stable(lap_q)); // R7
endmodule

// File: rtl/rd_return.sv
module rd_return (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_en_i,
  input  logic       rd_mem_i,
  input  logic [7:0] rd_data_i,
  input  logic [7:0] mem_rdata_i,
  output logic [7:0] rdata_o
);
  logic [7:0] rdata_q;
  logic       mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      mem_q   <= 1'b0;
    end else begin
      rdata_q <= rd_en_i ? rd_data_i : 8'h00;
      mem_q   <= rd_mem_i;
    end
  end

  // memory byte arrives one cycle after the strobe
  assign rdata_o = mem_q ? mem_rdata_i : rdata_q;
endmodule

// File: rtl/paged_addr_unit.sv
module paged_addr_unit
  import paddr_pkg::*;
#(
  parameter int unsigned P_CPU_AW  = CPU_AW,
  parameter int unsigned P_PHYS_AW = PHYS_AW,
  parameter int unsigned P_PAGE_W  = PAGE_W,
  parameter int unsigned P_WIN_AW  = WIN_AW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [P_CPU_AW-1:0]  cpu_addr_i,
  output logic                 win_hit_o,
  output logic [P_PHYS_AW-1:0] xlat_addr_o,
  input  logic                 reg_sel_i,
  input  logic                 reg_we_i,
  input  logic [2:0]           reg_addr_i,
  input  logic [7:0]           reg_wdata_i,
  output logic [7:0]           reg_rdata_o,
  output logic [P_PHYS_AW-1:0] mem_addr_o,
  output logic                 mem_rd_o,
  output logic                 mem_wr_o,
  output logic [7:0]           mem_wdata_o,
  input  logic [7:0]           mem_rdata_i
);
  localparam int unsigned HI_W = P_PHYS_AW - 16;

  logic [P_PAGE_W-1:0]  page_q;
  logic [P_PHYS_AW-1:0] lap;
  logic                 wr_cyc, rd_cyc;
  logic                 lap_wr, lap_add;
  logic [1:0]           lap_lane;
  logic [7:0]           rd_mux;

  assign wr_cyc = reg_sel_i &&  reg_we_i;
  assign rd_cyc = reg_sel_i && !reg_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                page_q <= '0;
    else if (wr_cyc && reg_addr_i == OFF_PAGE)  page_q <= reg_wdata_i[P_PAGE_W-1:0];
  end

  page_xlat #(
    .CPU_AW (P_CPU_AW),
    .WIN_AW (P_WIN_AW),
    .PAGE_W (P_PAGE_W),
    .PHYS_AW(P_PHYS_AW),
    .WIN_TAG(2'b10)
  ) u_xlat (
    .cpu_addr_i(cpu_addr_i),
    .page_i    (page_q),
    .hit_o     (win_hit_o),
    .phys_o    (xlat_addr_o)
  );

  always_comb begin
    lap_wr   = 1'b0;
    lap_lane = 2'd0;
    case (reg_addr_i)
      OFF_LAP_HI:  begin lap_wr = wr_cyc; lap_lane = 2'd0; end
      OFF_LAP_MID: begin lap_wr = wr_cyc; lap_lane = 2'd1; end
      OFF_LAP_LO:  begin lap_wr = wr_cyc; lap_lane = 2'd2; end
      default: ;
    endcase
  end
  assign lap_add = wr_cyc && reg_addr_i == OFF_ADD;

  lin_ptr #(.PHYS_AW(P_PHYS_AW)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (lap_wr),
    .wr_lane_i(lap_lane),
    .add_en_i (lap_add),
    .wdata_i  (reg_wdata_i),
    .lap_o    (lap)
  );

  assign mem_addr_o  = lap;
  assign mem_wdata_o = reg_wdata_i;
  assign mem_rd_o    = rd_cyc && reg_addr_i == OFF_DATA;
  assign mem_wr_o    = wr_cyc && reg_addr_i == OFF_DATA;

  always_comb begin
    case (reg_addr_i)
      OFF_PAGE:    rd_mux = 8'(page_q);
      OFF_LAP_HI:  rd_mux = {{(8-HI_W){1'b0}}, lap[P_PHYS_AW-1:16]};
      OFF_LAP_MID: rd_mux = lap[15:8];
      OFF_LAP_LO:  rd_mux = lap[7:0];
      default:     rd_mux = 8'h00;
    endcase
  end

  rd_return u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_cyc),
    .rd_mem_i   (mem_rd_o),
    .rd_data_i  (rd_mux),
    .mem_rdata_i(mem_rdata_i),
    .rdata_o    (reg_rdata_o)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o})); // R10
  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_sel_i && reg_we_i && reg_addr_i == OFF_PAGE) |=> $stable(page_q)); // R3
  AST_ADD_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i && !reg_we_i && reg_addr_i == OFF_ADD) |=> reg_rdata_o == 8'h00); // R8
  AST_LAP_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i && !reg_we_i && reg_addr_i == OFF_LAP_HI) |=> reg_rdata_o[7:HI_W] == '0); // R4
endmodule

// File: tb/tb_paged_addr_unit.sv
module tb_paged_addr_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic        win_hit_o;
  logic [21:0] xlat_addr_o;
  logic        reg_sel_i = 1'b0, reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [21:0] mem_addr_o;
  logic        mem_rd_o, mem_wr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_addr_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr_i),
    .win_hit_o(win_hit_o), .xlat_addr_o(xlat_addr_o),
    .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  // behavioural memory, sparse
  logic [7:0] mem [int];
  function automatic logic [7:0] mget(int a);
    if (mem.exists(a)) return mem[a];
    return 8'((a & 255) ^ ((a >> 8) & 255) ^ ((a >> 16) & 255) ^ 8'h5A);
  endfunction
  always @(posedge clk) begin
    if (mem_wr_o) mem[int'(mem_addr_o)] = mem_wdata_o;
    if (mem_rd_o) mem_rdata_i <= mget(int'(mem_addr_o));
  end

  // reference state
  int m_page = 0;
  int m_lap  = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int xlat(int ca);
    if (ca >= 'h8000 && ca <= 'hBFFF) return (m_page << 14) | (ca & 'h3FFF);
    return ca;
  endfunction

  // one bus cycle: drive at negedge, check combinational outputs, advance, check read return
  task automatic cyc(bit sel, bit we, int a, int d, int ca, string req);
    bit   rd, wr, exp_v;
    int   exp_d;
    int   s;
    reg_sel_i   = sel;
    reg_we_i    = we;
    reg_addr_i  = 3'(a);
    reg_wdata_i = 8'(d);
    cpu_addr_i  = 16'(ca);
    #1;
    rd = sel && !we && a == 4;
    wr = sel && we && a == 4;
    check({req, " strobe rd (R5/R10)"}, 32'(mem_rd_o), 32'(rd));
    check({req, " strobe wr (R6/R10)"}, 32'(mem_wr_o), 32'(wr));
    if (rd || wr) check({req, " mem addr (R5/R6/R9)"}, 32'(mem_addr_o), m_lap);
    if (wr) check({req, " mem wdata (R6)"}, 32'(mem_wdata_o), d);
    check({req, " xlat (R1/R2)"}, 32'(xlat_addr_o), xlat(ca));
    check({req, " hit (R1/R2)"}, 32'(win_hit_o), 32'(ca >= 'h8000 && ca <= 'hBFFF));
    exp_v = sel && !we;
    case (a)
      0: exp_d = m_page;
      1: exp_d = m_lap >> 16;
      2: exp_d = (m_lap >> 8) & 255;
      3: exp_d = m_lap & 255;
      4: exp_d = mget(m_lap);
      default: exp_d = 0;
    endcase
    if (sel && we) begin
      case (a)
        0: m_page = d & 255;
        1: m_lap = (m_lap & 'hFFFF) | ((d & 'h3F) << 16);
        2: m_lap = (m_lap & 'h3F00FF) | ((d & 255) << 8);
        3: m_lap = (m_lap & 'h3FFF00) | (d & 255);
        5: begin
          s = (d & 128) != 0 ? (d & 255) - 256 : (d & 255);
          m_lap = (m_lap + s + 4194304) % 4194304;
        end
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    if (exp_v) check({req, " rdata (R11)"}, 32'(reg_rdata_o), exp_d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset rd strobe", 32'(mem_rd_o), 0);
    check("R10 reset wr strobe", 32'(mem_wr_o), 0);
    check("R11 reset rdata", 32'(reg_rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset values
    cyc(1, 0, 0, 0, 'h1234, "R3 reset page");
    cyc(1, 0, 1, 0, 'h0000, "R4 reset lap hi");
    cyc(1, 0, 3, 0, 'hFFFF, "R4 reset lap lo");
    // window translation
    cyc(1, 1, 0, 'h3C, 'h8000, "R3 write page");
    cyc(1, 0, 0, 0, 'h8000, "R3 read page");
    cyc(0, 0, 0, 0, 'hBFFF, "R1 window top");
    cyc(0, 0, 0, 0, 'hC000, "R2 above window");
    cyc(0, 0, 0, 0, 'h7FFF, "R2 below window");
    cyc(1, 1, 0, 'hFF, 'h9ABC, "R1 page ff");
    cyc(0, 0, 0, 0, 'hA001, "R1 page ff hit");
    // pointer bytes
    cyc(1, 1, 1, 'hFF, 0, "R4 write lap hi");
    cyc(1, 0, 1, 0, 0, "R4 lap hi masks");
    cyc(1, 1, 2, 'h12, 0, "R4 write mid");
    cyc(1, 1, 3, 'h34, 0, "R4 write lo");
    cyc(1, 0, 2, 0, 0, "R4 read mid");
    cyc(1, 0, 3, 0, 0, "R4 read lo");
    // data port
    cyc(1, 0, 4, 0, 0, "R5 data read");
    cyc(1, 1, 4, 'hA5, 0, "R6 data write");
    cyc(1, 0, 4, 0, 0, "R6 data readback");
    // signed add
    cyc(1, 1, 5, 'h7F, 0, "R7 add 127");
    cyc(1, 0, 3, 0, 0, "R7 after +127");
    cyc(1, 1, 5, 'h80, 0, "R7 add -128");
    cyc(1, 0, 3, 0, 0, "R7 after -128");
    cyc(1, 1, 5, 'hFF, 0, "R7 add -1");
    cyc(1, 0, 2, 0, 0, "R7 after -1");
    cyc(1, 1, 5, 'h00, 0, "R7 add 0");
    cyc(1, 0, 3, 0, 0, "R7 after 0");
    // wrap both ways
    cyc(1, 1, 1, 0, 0, "R7 clr hi");
    cyc(1, 1, 2, 0, 0, "R7 clr mid");
    cyc(1, 1, 3, 0, 0, "R7 clr lo");
    cyc(1, 1, 5, 'hFF, 0, "R7 wrap down");
    cyc(1, 0, 1, 0, 0, "R7 wrap hi");
    cyc(1, 0, 3, 0, 0, "R7 wrap lo");
    cyc(1, 1, 5, 'h01, 0, "R7 wrap up");
    cyc(1, 0, 1, 0, 0, "R7 wrap up hi");
    // add reads zero
    cyc(1, 0, 5, 0, 0, "R8 add read");
    // back-to-back pointer change then data access
    cyc(1, 1, 5, 'h40, 0, "R9 add");
    cyc(1, 1, 4, 'h5C, 0, "R9 write at new ptr");
    cyc(1, 1, 3, 'h41, 0, "R9 lo write");
    cyc(1, 0, 4, 0, 0, "R9 read after byte write");
    cyc(1, 1, 3, 'h40, 0, "R9 lo back");
    cyc(1, 0, 4, 0, 0, "R9 read written byte");
    // unused offsets
    cyc(1, 1, 6, 'h77, 0, "R10 write off6");
    cyc(1, 1, 7, 'h88, 0, "R10 write off7");
    cyc(1, 0, 6, 0, 0, "R10 read off6");
    cyc(1, 0, 7, 0, 0, "R10 read off7");
    cyc(1, 0, 0, 0, 0, "R10 page unchanged");
    cyc(1, 0, 3, 0, 0, "R10 lap unchanged");
    cyc(0, 0, 0, 0, 0, "R10 idle");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule